// File: doc/BRIEF.md
# Autorange Step Controller

This block chooses the range of an autoranging meter. It counts range-oscillator pulses during each measurement period, and the count is read as a command when that period ends. Five pulses ask for the next higher range and a single pulse asks for the next lower one. Every other count leaves the range as it is. Range steps are bounded by the ladder limits, and on the DC-volts function the top limit is lower. An accepted step starts a settling lockout. While the lockout runs, no further step is taken, and it runs longer when input filtering is selected.

A second counter watches the converter's pulses within each measurement. On the twelfth pulse it raises an overrange flag, which stands for an input more than 20 percent above full scale. The flag holds until the next measurement starts. The range index runs from 0 to 4, where index 0 is the lowest range and index 4 is the highest. The analog switching that follows the index lies outside the block.

Top module: `autorange_ctrl`

## Requirements
- R1: During and immediately after reset, `range_o` is 4 and `up_o`, `dn_o`, `busy_o` and `ovr_o` are all 0.
- R2: Range pulses count only while `meas_i` is high. The pulse count clears when a measurement starts, so pulses from before a measurement or from an earlier one have no effect.
- R3: A measurement that ends with a count of exactly five steps `range_o` up by one. `up_o` goes high for exactly one clock cycle, two cycles after `meas_i` falls.
- R4: A measurement that ends with a count of exactly one steps `range_o` down by one, with a one-cycle pulse on `dn_o`.
- R5: Counts of 0, 2, 3 and 4 change nothing. The counter has six states, so six pulses read as zero and seven pulses read as one (down).
- R6: `range_o` never goes above 4, and an up request at 4 is ignored with no strobe.
- R7: When `func_dcv_i` is 1, an up request at index 3 or above is ignored. Down requests are still honoured.
- R8: A down request at index 0 is ignored, with no strobe and no lockout.
- R9: After each step `busy_o` is high for exactly SETTLE_NORM (1000) cycles, starting on the strobe cycle. Any request that arrives while `busy_o` is high is ignored.
- R10: If `filt_i` is 1 at the moment of a step, the lockout lasts SETTLE_FILT (4000) cycles. A later change of `filt_i` does not shorten it.
- R11: `ovr_o` sets on the twelfth converter pulse within a measurement and does not set on the eleventh. It holds after the measurement ends and clears when the next measurement starts.
- R12: The command counter always holds one of its six legal states, and any unused state returns to zero. Repeated wraps therefore keep the count modulo six, so thirteen pulses read as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_i | input | 1 | High during the measurement period |
| rng_pulse_i | input | 1 | Range-oscillator pulse; counted on its rising edge |
| conv_pulse_i | input | 1 | Converter pulse; counted on its rising edge |
| func_dcv_i | input | 1 | DC-volts function selected |
| filt_i | input | 1 | Input filtering selected |
| range_o | output | 3 | Range index, 0 (lowest) to 4 (highest) |
| up_o | output | 1 | One-cycle strobe on an up step |
| dn_o | output | 1 | One-cycle strobe on a down step |
| busy_o | output | 1 | Settling lockout active |
| ovr_o | output | 1 | Overrange flag |

## Verification
The bench probes the counter modulus with six, seven and thirteen pulses. A counter that saturates or never wraps would step on the wrong counts or miss those steps. It asks for steps past both ends of the ladder and past the DC-volts stop, where a missing limit would move the index out of bounds or fire a strobe. The lockout length is measured to the exact cycle for both filter settings, and the filter input is dropped during a long lockout. A design that re-read the filter input, or that counted off by one, would give a different length. The bench also places eleven and twelve converter pulses around the overrange threshold, and checks that the flag clears only when the next measurement starts.

// File: rtl/autorange_pkg.sv
package autorange_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_UP   = 2'd1,
    CMD_DOWN = 2'd2
  } ar_cmd_e;

endpackage

// File: rtl/ar_sample.sv
// Two-stage sampler: current and previous registered copy of each input bit.
module ar_sample #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] now_o,
  output logic [W-1:0] prev_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        now_o[g]  <= 1'b0;
        prev_o[g] <= 1'b0;
      end else begin
        now_o[g]  <= sig_i[g];
        prev_o[g] <= now_o[g];
      end
    end
  end
endmodule

// File: rtl/ar_cmd_counter.sv
// Modulo counter of range pulses within a measurement; decodes command at its end.
module ar_cmd_counter
  import autorange_pkg::*;
#(
  parameter int CMD_MOD    = 6,
  parameter int UP_COUNT   = 5,
  parameter int DOWN_COUNT = 1,
  localparam int CW = $clog2(CMD_MOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          meas_lvl_i,
  input  logic          meas_rise_i,
  input  logic          meas_fall_i,
  input  logic          pulse_rise_i,
  output ar_cmd_e       cmd_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST   = CW'(CMD_MOD - 1);
  localparam logic [CW-1:0] UP_V   = CW'(UP_COUNT);
  localparam logic [CW-1:0] DOWN_V = CW'(DOWN_COUNT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q > LAST) begin
      cnt_q <= '0;                       // unused state: recover
    end else if (meas_rise_i) begin
      cnt_q <= '0;
    end else if (meas_lvl_i && pulse_rise_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_comb begin
    cmd_o = CMD_NONE;
    if (meas_fall_i) begin
      if (cnt_q == UP_V)        cmd_o = CMD_UP;
      else if (cnt_q == DOWN_V) cmd_o = CMD_DOWN;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ar_range_step.sv
// Range register with ladder limits and one-cycle step strobes.
module ar_range_step
  import autorange_pkg::*;
#(
  parameter int NUM_RANGES  = 5,
  parameter int DCV_TOP     = 3,
  parameter int RESET_RANGE = 4,
  localparam int RW = $clog2(NUM_RANGES)
) (
  input  logic          clk,
  input  logic          rst,
  input  ar_cmd_e       cmd_i,
  input  logic          func_dcv_i,
  input  logic          busy_i,
  output logic          step_o,
  output logic [RW-1:0] range_o,
  output logic          up_o,
  output logic          dn_o
);
  localparam logic [RW-1:0] TOP_ALL = RW'(NUM_RANGES - 1);
  localparam logic [RW-1:0] TOP_DCV = RW'(DCV_TOP);
  localparam logic [RW-1:0] BOTTOM  = '0;
  localparam logic [RW-1:0] RST_V   = RW'(RESET_RANGE);

  logic [RW-1:0] range_q;
  logic [RW-1:0] top_lim;
  logic          take_up, take_dn;

  always_comb begin
    top_lim = func_dcv_i ? TOP_DCV : TOP_ALL;
    take_up = (cmd_i == CMD_UP)   && !busy_i && (range_q < top_lim);
    take_dn = (cmd_i == CMD_DOWN) && !busy_i && (range_q > BOTTOM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      range_q <= RST_V;
      up_o    <= 1'b0;
      dn_o    <= 1'b0;
    end else begin
      up_o <= take_up;
      dn_o <= take_dn;
      if (take_up)      range_q <= range_q + 1'b1;
      else if (take_dn) range_q <= range_q - 1'b1;
    end
  end

  assign step_o  = take_up | take_dn;
  assign range_o = range_q;
endmodule

// File: rtl/ar_settle_timer.sv
// Settling lockout; length chosen by the filter input at the moment of start.
module ar_settle_timer #(
  parameter int SETTLE_NORM = 1000,
  parameter int SETTLE_FILT = 4000,
  localparam int LONGEST = (SETTLE_NORM > SETTLE_FILT) ? SETTLE_NORM : SETTLE_FILT,
  localparam int TW = $clog2(LONGEST)
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic filt_i,
  output logic busy_o
);
  localparam logic [TW-1:0] LOAD_N = TW'(SETTLE_NORM - 1);
  localparam logic [TW-1:0] LOAD_F = TW'(SETTLE_FILT - 1);

  logic [TW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      busy_o <= 1'b0;
    end else if (start_i) begin
      left_q <= filt_i ? LOAD_F : LOAD_N;
      busy_o <= 1'b1;
    end else if (busy_o) begin
      if (left_q == '0) busy_o <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/ar_ovr_detect.sv
// Counts converter pulses within a measurement; flags at the threshold.
module ar_ovr_detect #(
  parameter int OVR_PULSES = 12,
  localparam int OW = $clog2(OVR_PULSES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic meas_lvl_i,
  input  logic meas_rise_i,
  input  logic pulse_rise_i,
  output logic ovr_o
);
  localparam logic [OW-1:0] ARM = OW'(OVR_PULSES - 1);

  logic [OW-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
      ovr_o  <= 1'b0;
    end else if (meas_rise_i) begin
      seen_q <= '0;
      ovr_o  <= 1'b0;
    end else if (meas_lvl_i && pulse_rise_i && !ovr_o) begin
      seen_q <= seen_q + 1'b1;
      if (seen_q == ARM) ovr_o <= 1'b1;
    end
  end
endmodule

// File: rtl/autorange_ctrl.sv
module autorange_ctrl
  import autorange_pkg::*;
#(
  parameter int NUM_RANGES  = 5,
  parameter int DCV_TOP     = 3,
  parameter int RESET_RANGE = 4,
  parameter int CMD_MOD     = 6,
  parameter int UP_COUNT    = 5,
  parameter int DOWN_COUNT  = 1,
  parameter int OVR_PULSES  = 12,
  parameter int SETTLE_NORM = 1000,
  parameter int SETTLE_FILT = 4000,
  localparam int RW = $clog2(NUM_RANGES),
  localparam int CW = $clog2(CMD_MOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          meas_i,
  input  logic          rng_pulse_i,
  input  logic          conv_pulse_i,
  input  logic          func_dcv_i,
  input  logic          filt_i,
  output logic [RW-1:0] range_o,
  output logic          up_o,
  output logic          dn_o,
  output logic          busy_o,
  output logic          ovr_o
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] s_now, s_prev, s_rise;
  logic            meas_lvl, meas_rise, meas_fall;
  ar_cmd_e         cmd;
  logic [CW-1:0]   cmd_cnt;
  logic            step;

  ar_sample #(.W(NSIG)) u_sample (
    .clk    (clk),
    .rst    (rst),
    .sig_i  ({conv_pulse_i, rng_pulse_i, meas_i}),
    .now_o  (s_now),
    .prev_o (s_prev)
  );

  assign s_rise    = s_now & ~s_prev;
  assign meas_lvl  = s_now[0];
  assign meas_rise = s_rise[0];
  assign meas_fall = s_prev[0] & ~s_now[0];

  ar_cmd_counter #(
    .CMD_MOD(CMD_MOD), .UP_COUNT(UP_COUNT), .DOWN_COUNT(DOWN_COUNT)
  ) u_cmd (
    .clk          (clk),
    .rst          (rst),
    .meas_lvl_i   (meas_lvl),
    .meas_rise_i  (meas_rise),
    .meas_fall_i  (meas_fall),
    .pulse_rise_i (s_rise[1]),
    .cmd_o        (cmd),
    .cnt_o        (cmd_cnt)
  );

  ar_range_step #(
    .NUM_RANGES(NUM_RANGES), .DCV_TOP(DCV_TOP), .RESET_RANGE(RESET_RANGE)
  ) u_step (
    .clk        (clk),
    .rst        (rst),
    .cmd_i      (cmd),
    .func_dcv_i (func_dcv_i),
    .busy_i     (busy_o),
    .step_o     (step),
    .range_o    (range_o),
    .up_o       (up_o),
    .dn_o       (dn_o)
  );

  ar_settle_timer #(
    .SETTLE_NORM(SETTLE_NORM), .SETTLE_FILT(SETTLE_FILT)
  ) u_settle (
    .clk     (clk),
    .rst     (rst),
    .start_i (step),
    .filt_i  (filt_i),
    .busy_o  (busy_o)
  );

  ar_ovr_detect #(.OVR_PULSES(OVR_PULSES)) u_ovr (
    .clk          (clk),
    .rst          (rst),
    .meas_lvl_i   (meas_lvl),
    .meas_rise_i  (meas_rise),
    .pulse_rise_i (s_rise[2]),
    .ovr_o        (ovr_o)
  );
endmodule

// File: rtl/autorange_ctrl_chk.sv
module autorange_ctrl_chk #(
  parameter int NUM_RANGES  = 5,
  parameter int DCV_TOP     = 3,
  parameter int RESET_RANGE = 4,
  parameter int CMD_MOD     = 6,
  parameter int RW          = 3,
  parameter int CW          = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [RW-1:0] range_o,
  input logic          up_o,
  input logic          dn_o,
  input logic          busy_o,
  input logic          ovr_o,
  input logic          func_dcv_i,
  input logic          meas_lvl,
  input logic [CW-1:0] cmd_cnt
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (range_o == RW'(RESET_RANGE) && !up_o && !dn_o && !busy_o && !ovr_o));

  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({up_o, dn_o}));

  a_r3_up_step: assert property (@(posedge clk) disable iff (rst)
    up_o |-> (range_o == $past(range_o) + 1'b1));

  a_r4_dn_step: assert property (@(posedge clk) disable iff (rst)
    dn_o |-> (range_o == $past(range_o) - 1'b1));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!up_o && !dn_o) |-> $stable(range_o));

  a_r6_top: assert property (@(posedge clk) disable iff (rst)
    range_o <= RW'(NUM_RANGES - 1));

  a_r7_dcv_stop: assert property (@(posedge clk) disable iff (rst)
    (up_o && $past(func_dcv_i)) |-> (range_o <= RW'(DCV_TOP)));

  a_r9_busy_on_step: assert property (@(posedge clk) disable iff (rst)
    (up_o || dn_o) |-> busy_o);

  a_r9_no_step_while_busy: assert property (@(posedge clk) disable iff (rst)
    (up_o || dn_o) |-> !$past(busy_o));

  a_r11_ovr_in_meas: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_o) |-> $past(meas_lvl));

  a_r12_cnt_legal: assert property (@(posedge clk) disable iff (rst)
    cmd_cnt <= CW'(CMD_MOD - 1));
endmodule

bind autorange_ctrl autorange_ctrl_chk #(
  .NUM_RANGES(NUM_RANGES), .DCV_TOP(DCV_TOP), .RESET_RANGE(RESET_RANGE),
  .CMD_MOD(CMD_MOD), .RW(RW), .CW(CW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .range_o    (range_o),
  .up_o       (up_o),
  .dn_o       (dn_o),
  .busy_o     (busy_o),
  .ovr_o      (ovr_o),
  .func_dcv_i (func_dcv_i),
  .meas_lvl   (meas_lvl),
  .cmd_cnt    (cmd_cnt)
);

// File: tb/autorange_ctrl_bench.sv
module autorange_ctrl_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst, meas, rp, cp, dcv, filt;
  logic [2:0] range;
  logic       up, dn, busy, ovr;

  autorange_ctrl u_autorange_ctrl (
    .clk(clk), .rst(rst), .meas_i(meas), .rng_pulse_i(rp), .conv_pulse_i(cp),
    .func_dcv_i(dcv), .filt_i(filt), .range_o(range), .up_o(up), .dn_o(dn),
    .busy_o(busy), .ovr_o(ovr)
  );

  int checks = 0, fails = 0;
  int n_up = 0, n_dn = 0, n_busy = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    #3;
    if (up)   n_up++;
    if (dn)   n_dn++;
    if (busy) n_busy++;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_rng(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) rp = 1'b1;
      @(negedge clk) rp = 1'b0;
    end
  endtask

  task automatic pulse_conv(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cp = 1'b1;
      @(negedge clk) cp = 1'b0;
    end
  endtask

  task automatic run_meas(int nr, int nc);
    n_up = 0; n_dn = 0; n_busy = 0;
    @(negedge clk) meas = 1'b1;
    repeat (2) @(negedge clk);
    pulse_rng(nr);
    pulse_conv(nc);
    @(negedge clk);
    @(negedge clk) meas = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 10000 && busy; g++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; meas = 0; rp = 0; cp = 0; dcv = 0; filt = 0;
    repeat (3) @(negedge clk);
    chk("R1", "range in reset", range, 4);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "range after reset", range, 4);
    chk("R1", "strobes/busy/ovr", {up, dn, busy, ovr}, 0);
  endtask

  task automatic t_down_settle();
    run_meas(1, 0);
    chk("R4", "range after one pulse", range, 3);
    chk("R4", "dn strobe cycles", n_dn, 1);
    chk("R4", "no up strobe", n_up, 0);
    wait_idle();
    chk("R9", "normal lockout length", n_busy, 1000);
  endtask

  task automatic t_block_busy();
    run_meas(1, 0);
    chk("R4", "second down step", range, 2);
    run_meas(1, 0);
    chk("R9", "request while busy ignored", range, 2);
    chk("R9", "no strobe while busy", n_dn, 0);
    wait_idle();
  endtask

  task automatic t_gating();
    pulse_rng(5);
    run_meas(0, 0);
    chk("R2", "pulses outside measurement", range, 2);
    chk("R2", "no up strobe", n_up, 0);
    run_meas(3, 0);
    run_meas(2, 0);
    chk("R2", "count clears between measurements", range, 2);
    chk("R2", "no strobes", n_up + n_dn, 0);
  endtask

  task automatic t_other_counts();
    int cnts[5] = '{0, 2, 3, 4, 6};
    foreach (cnts[i]) begin
      run_meas(cnts[i], 0);
      chk("R5", $sformatf("count %0d leaves range", cnts[i]), range, 2);
      chk("R5", "no strobe", n_up + n_dn, 0);
    end
    run_meas(7, 0);
    chk("R5", "seven pulses wrap to down", range, 1);
    wait_idle();
  endtask

  task automatic t_wrap();
    run_meas(13, 0);
    chk("R12", "thirteen pulses read as one", range, 0);
    chk("R12", "dn strobe", n_dn, 1);
    wait_idle();
  endtask

  task automatic t_bottom();
    run_meas(1, 0);
    chk("R8", "down at bottom ignored", range, 0);
    chk("R8", "no strobe", n_dn, 0);
    chk("R8", "no lockout", n_busy, 0);
  endtask

  task automatic t_up();
    run_meas(5, 0);
    chk("R3", "five pulses step up", range, 1);
    chk("R3", "up strobe cycles", n_up, 1);
    wait_idle();
    run_meas(11, 0);
    chk("R5", "eleven pulses read as five", range, 2);
    wait_idle();
    run_meas(5, 0); wait_idle();
    run_meas(5, 0);
    chk("R3", "up to top", range, 4);
    wait_idle();
  endtask

  task automatic t_top();
    run_meas(5, 0);
    chk("R6", "up at top ignored", range, 4);
    chk("R6", "no strobe", n_up, 0);
  endtask

  task automatic t_dcv();
    dcv = 1'b1;
    run_meas(1, 0);
    chk("R7", "down allowed on dc volts", range, 3);
    wait_idle();
    run_meas(5, 0);
    chk("R7", "up stopped at index 3", range, 3);
    chk("R7", "no strobe", n_up, 0);
    dcv = 1'b0;
  endtask

  task automatic t_filter();
    filt = 1'b1;
    run_meas(1, 0);
    filt = 1'b0;
    chk("R10", "step taken", range, 2);
    wait_idle();
    chk("R10", "filtered lockout length", n_busy, 4000);
  endtask

  task automatic t_ovr();
    run_meas(0, 11);
    chk("R11", "eleven pulses no flag", ovr, 0);
    run_meas(0, 12);
    chk("R11", "twelve pulses set flag", ovr, 1);
    repeat (5) @(negedge clk);
    chk("R11", "flag holds after measurement", ovr, 1);
    @(negedge clk) meas = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", "flag cleared at next start", ovr, 0);
    meas = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_down_settle();
    t_block_busy();
    t_gating();
    t_other_counts();
    t_wrap();
    t_bottom();
    t_up();
    t_top();
    t_dcv();
    t_filter();
    t_ovr();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule